// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a virtual address into a physical address. It does this by reading one 64-bit table entry per level from a four-level radix page table held in memory.

A requester presents a 64-bit virtual address, an access kind, a user-mode flag and the root physical page number of the current address space. The walker then issues one read per level on a valid/ready memory port and checks each entry it gets back. It answers with one of three outcomes:
- a translated physical address, together with the last entry read;
- a page fault when an entry is not present;
- a protection fault when an entry forbids the requested access.

A fault response also reports the level at which the walk stopped. Only one walk is in progress at any time.

Top module: `xlat_walker`

## Requirements
- R1: Bits 63:48 of the virtual address have no effect on any output. Bits 47:12 hold four 9-bit indices, with the first level using bits 47:39 and the last level using bits 20:12. Bits 11:0 are the page offset.
- R2: Each read address equals the current physical page number shifted left by 12, ORed with the level's 9-bit index shifted left by 3. Every read address is therefore a multiple of 8.
- R3: The first read uses the `ptbr` input as its physical page number. Each later read uses bits 51:12 of the entry returned by the previous read.
- R4: An entry with bit 0 (present) clear ends the walk with status 1 (page fault). This check takes priority over the permission checks on the same entry.
- R5: A present entry ends the walk with status 2 (protection fault) in any of these cases:
  - a write (access code 1) finds bit 1 clear;
  - a user-mode access finds bit 2 clear;
  - an execute (access code 2) finds bit 63 set.

  Access codes 0 and 3 are reads. The check applies at every level.
- R6: A walk with no fault makes exactly four reads and ends with status 0. The physical address is then bits 51:12 of the fourth entry followed by the 12-bit offset, `respEntry` is the fourth entry, and `respLevel` is 3.
- R7: A fault response carries the stopping level (0 to 3) in `respLevel` and the faulting entry in `respEntry`. No read is issued after the faulting entry.
- R8: `reqReady` is high only while no walk is active. It falls after a request is accepted and stays low until the result has been returned. `respValid` is high for exactly one cycle per walk.
- R9: Once raised, `memReqValid` stays high with an unchanged address until `memReqReady` is seen. Each level issues exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted this cycle if valid |
| reqVaddr | input | 64 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| reqUser | input | 1 | Access made from user mode |
| ptbr | input | 40 | Root physical page number of the table |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 52 | Byte address of the entry |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 64 | Entry contents |
| respValid | output | 1 | Result present for one cycle |
| respStatus | output | 2 | 0 translated, 1 page fault, 2 protection fault |
| respLevel | output | 2 | Level at which the walk ended |
| respPaddr | output | 52 | Physical address (valid with status 0) |
| respEntry | output | 64 | Last entry read |

## Verification
The bench builds the walker with its default parameters: four levels, 9-bit indices, a 12-bit offset and a 40-bit page number.

At that size it can sweep every combination of:
- access kind and user flag;
- the three permission bits;
- the level that carries the restricted or absent entry.

It also varies the stall time of the memory handshake. This covers the page-fault-over-protection priority at each level, the stopping level and the read count of every early exit, and the independence of the result from the upper address bits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_PAGE = 2'd1,
    ST_PROT = 2'd2
  } rsp_e;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_NOEXEC  = 63;

  typedef struct packed {
    logic load;  // capture request fields, restart at level 0
    logic take;  // capture returned entry and its page number
    logic step;  // advance to the next level
  } strobe_t;

endpackage

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int LVL_N = 4,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PPN_W = 40,
  localparam int VA_USED = LVL_N * IDX_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W,
  localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [VA_USED-1:0] reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  input  logic [PPN_W-1:0]   ptbr,
  input  logic [63:0]        memRspData,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               notPresent,
  output logic               deny,
  output logic               lastLevel,
  output logic [LVL_W-1:0]   level,
  output logic [PA_W-1:0]    paddr,
  output logic [63:0]        entry
);

  localparam int ENT_SH = 3;

  logic [VA_USED-1:0] vaReg;
  logic [1:0]         accReg;
  logic               usrReg;
  logic [PPN_W-1:0]   curPpn;
  logic [LVL_W-1:0]   lvlReg;
  logic [63:0]        entryReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      accReg   <= '0;
      usrReg   <= 1'b0;
      curPpn   <= '0;
      lvlReg   <= '0;
      entryReg <= '0;
    end else if (stb.load) begin
      vaReg  <= reqVaddr;
      accReg <= reqAccess;
      usrReg <= reqUser;
      curPpn <= ptbr;
      lvlReg <= '0;
    end else begin
      if (stb.take) begin
        entryReg <= memRspData;
        curPpn   <= memRspData[OFF_W +: PPN_W];
      end
      if (stb.step) lvlReg <= lvlReg + 1'b1;
    end
  end

  // Index slices, lowest slice belongs to the last level.
  logic [IDX_W-1:0] idxArr [LVL_N];
  for (genvar g = 0; g < LVL_N; g++) begin : g_slice
    assign idxArr[g] = vaReg[OFF_W + g*IDX_W +: IDX_W];
  end

  logic [LVL_W-1:0] sliceSel;
  logic [IDX_W-1:0] curIdx;
  assign sliceSel = LVL_W'(LVL_N - 1) - lvlReg;
  assign curIdx   = idxArr[sliceSel];

  assign memReqAddr = (PA_W'(curPpn) << OFF_W) | (PA_W'(curIdx) << ENT_SH);

  assign notPresent = !memRspData[BIT_PRESENT];
  assign deny = ((accReg == ACC_WRITE) && !memRspData[BIT_WRITE]) ||
                (usrReg && !memRspData[BIT_USER]) ||
                ((accReg == ACC_EXEC) && memRspData[BIT_NOEXEC]);

  assign lastLevel = (lvlReg == LVL_W'(LVL_N - 1));
  assign level     = lvlReg;
  assign paddr     = {curPpn, vaReg[OFF_W-1:0]};
  assign entry     = entryReg;

  AST_ROOT_BASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> memReqAddr[PA_W-1:OFF_W] == $past(ptbr)) else $error("root base"); // R3

  AST_NEXT_BASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> memReqAddr[PA_W-1:OFF_W] == $past(memRspData[OFF_W +: PPN_W])) else $error("next base"); // R3

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    notPresent,
  input  logic    deny,
  input  logic    lastLevel,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    respValid,
  output rsp_e    status,
  output strobe_t stb
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e state, stateNxt;
  rsp_e   statusNxt;

  always_comb begin
    stateNxt  = state;
    statusNxt = status;
    stb       = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.load  = 1'b1;
          statusNxt = ST_OK;
          stateNxt  = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (memReqReady) stateNxt = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          stb.take = 1'b1;
          if (notPresent) begin
            statusNxt = ST_PAGE;
            stateNxt  = S_DONE;
          end else if (deny) begin
            statusNxt = ST_PROT;
            stateNxt  = S_DONE;
          end else if (lastLevel) begin
            statusNxt = ST_OK;
            stateNxt  = S_DONE;
          end else begin
            stb.step = 1'b1;
            stateNxt = S_ISSUE;
          end
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      status <= ST_OK;
    end else begin
      state  <= stateNxt;
      status <= statusNxt;
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign respValid   = (state == S_DONE);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady) else $error("busy"); // R8

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady) else $error("pulse"); // R8

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid) else $error("hold"); // R9

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int LVL_N = 4,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PPN_W = 40,
  localparam int VA_USED = LVL_N * IDX_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W,
  localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [63:0]      reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic             reqUser,
  input  logic [PPN_W-1:0] ptbr,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [63:0]      memRspData,
  output logic             respValid,
  output logic [1:0]       respStatus,
  output logic [LVL_W-1:0] respLevel,
  output logic [PA_W-1:0]  respPaddr,
  output logic [63:0]      respEntry
);

  strobe_t stb;
  rsp_e    status;
  logic    notPresent, deny, lastLevel;
  logic    unusedHighBits;

  assign unusedHighBits = ^reqVaddr[63:VA_USED];

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .notPresent (notPresent),
    .deny       (deny),
    .lastLevel  (lastLevel),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .respValid  (respValid),
    .status     (status),
    .stb        (stb)
  );

  xlat_dpath #(
    .LVL_N(LVL_N), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqVaddr  (reqVaddr[VA_USED-1:0]),
    .reqAccess (reqAccess),
    .reqUser   (reqUser),
    .ptbr      (ptbr),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .notPresent(notPresent),
    .deny      (deny),
    .lastLevel (lastLevel),
    .level     (respLevel),
    .paddr     (respPaddr),
    .entry     (respEntry)
  );

  assign respStatus = status;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr)) else $error("addr hold"); // R9

  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000) else $error("align"); // R2

  AST_PAGE_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respStatus == ST_PAGE |-> !respEntry[BIT_PRESENT]) else $error("page"); // R4

  AST_PROT_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respStatus == ST_PROT |-> respEntry[BIT_PRESENT]) else $error("prot"); // R4

  AST_OK_LAST_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respStatus == ST_OK |-> respLevel == LVL_W'(LVL_N - 1)) else $error("ok lvl"); // R6

endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [39:0] ptbr = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        respValid;
  logic [1:0]  respStatus;
  logic [1:0]  respLevel;
  logic [51:0] respPaddr;
  logic [63:0] respEntry;

  int nChk = 0;
  int nFail = 0;
  logic [63:0] tblEntry [4];

  always #5 clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser), .ptbr(ptbr),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .respValid(respValid),
    .respStatus(respStatus), .respLevel(respLevel), .respPaddr(respPaddr),
    .respEntry(respEntry)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] ppnOf(input int v, input int l);
    return 40'h0A_0000_0000 + 40'(v) * 40'd4099 + 40'(l) * 40'd65537;
  endfunction

  function automatic logic [39:0] ptbrOf(input int v);
    return 40'h0C_0FFE_E123 + 40'(v) * 40'd31;
  endfunction

  function automatic logic [8:0] idxOf(input int v, input int l);
    return 9'((v * 37 + l * 101) % 512);
  endfunction

  function automatic logic [11:0] offOf(input int v);
    return 12'((v * 13 + 5) % 4096);
  endfunction

  // flags: {noexec, user, write, present}
  function automatic logic [63:0] entryOf(input int v, input int l, input logic [3:0] f);
    return {f[3], 11'h2A5, ppnOf(v, l), 9'h1C3, f[2], f[1], f[0]};
  endfunction

  task automatic runWalk(input int v, input logic [15:0] hi, input logic [1:0] acc,
                         input bit usr, input int stall, input logic [1:0] expSt,
                         input int expLvl, input string tag);
    logic [47:0] low;
    logic [51:0] expAddr;
    int reads;
    int cyc;
    bit got;
    bit readyLeak;
    int stopLvl;
    low = '0;
    for (int l = 0; l < 4; l++) low = (low << 9) | 48'(idxOf(v, l));
    low = (low << 12) | 48'(offOf(v));
    @(negedge clk);
    reqVaddr = {hi, low};
    reqAccess = acc;
    reqUser = usr;
    ptbr = ptbrOf(v);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reads = 0; cyc = 0; got = 0; readyLeak = 0;
    while (!got && cyc < 400) begin
      if (respValid) begin
        got = 1;
      end else begin
        if (reqReady) readyLeak = 1;
        if (memReqValid) begin
          if (reads < 4) begin
            expAddr = {(reads == 0) ? ptbrOf(v) : ppnOf(v, reads - 1), idxOf(v, reads), 3'b000};
            chk(memReqAddr == expAddr, {tag, " R2 R3 entry address"}, 64'(memReqAddr), 64'(expAddr));
          end
          for (int s = 0; s < stall; s++) @(negedge clk);
          memReqReady = 1'b1;
          @(negedge clk);
          memReqReady = 1'b0;
          memRspData = tblEntry[reads % 4];
          memRspValid = 1'b1;
          @(negedge clk);
          memRspValid = 1'b0;
          reads++;
          cyc += stall + 2;
        end else begin
          @(negedge clk);
          cyc++;
        end
      end
    end
    chk(got, {tag, " R8 response arrived"}, 64'(got), 64'd1);
    if (got) begin
      chk(!readyLeak, {tag, " R8 ready low during walk"}, 64'(readyLeak), 64'd0);
      chk(respStatus == expSt, {tag, " R4 R5 R6 status"}, 64'(respStatus), 64'(expSt));
      stopLvl = (expSt == 2'd0) ? 3 : expLvl;
      chk(reads == stopLvl + 1, {tag, " R7 R9 read count"}, 64'(reads), 64'(stopLvl + 1));
      chk(int'(respLevel) == stopLvl, {tag, " R7 level"}, 64'(respLevel), 64'(stopLvl));
      chk(respEntry == tblEntry[stopLvl], {tag, " R7 entry"}, respEntry, tblEntry[stopLvl]);
      if (expSt == 2'd0)
        chk(respPaddr == {ppnOf(v, 3), offOf(v)}, {tag, " R6 R1 paddr"},
            64'(respPaddr), 64'({ppnOf(v, 3), offOf(v)}));
      @(negedge clk);
      chk(reqReady && !respValid, {tag, " R8 idle after result"}, 64'({reqReady, respValid}), 64'b10);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : main
    int v;
    bit dn;
    logic [1:0] expSt;
    v = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReqValid && !respValid, "R8 reset state",
        64'({reqReady, memReqValid, respValid}), 64'b100);

    // R5: restricted flags at one level, sweep access kind and user flag
    for (int lv = 0; lv < 4; lv++)
      for (int f = 0; f < 8; f++)
        for (int a = 0; a < 3; a++)
          for (int u = 0; u < 2; u++) begin
            for (int l = 0; l < 4; l++)
              tblEntry[l] = entryOf(v, l, (l == lv) ? {f[2], f[1], f[0], 1'b1} : 4'b0111);
            dn = (a == 1 && !f[0]) || (u == 1 && !f[1]) || (a == 2 && f[2]);
            expSt = dn ? 2'd2 : 2'd0;
            runWalk(v, 16'h0, 2'(a), u[0], v % 3, expSt, lv, "R5 perm");
            v++;
          end

    // R4: absent entry at one level with any permission pattern
    for (int lv = 0; lv < 4; lv++)
      for (int f = 0; f < 8; f++)
        for (int a = 0; a < 3; a++) begin
          for (int l = 0; l < 4; l++)
            tblEntry[l] = entryOf(v, l, (l == lv) ? {f[2], f[1], f[0], 1'b0} : 4'b0111);
          runWalk(v, 16'h0, 2'(a), 1'b1, v % 4, 2'd1, lv, "R4 absent");
          v++;
        end

    // R1: upper address bits must not matter
    for (int k = 0; k < 8; k++) begin
      for (int l = 0; l < 4; l++) tblEntry[l] = entryOf(v, l, 4'b0111);
      runWalk(v, 16'hFFFF ^ 16'(k * 16'h1357), 2'd0, 1'b0, k % 2, 2'd0, 0, "R1 high bits set");
      runWalk(v, 16'h0000, 2'd0, 1'b0, 0, 2'd0, 0, "R1 high bits clear");
      v++;
    end

    // R5: access code 3 behaves as a read
    for (int l = 0; l < 4; l++) tblEntry[l] = entryOf(v, l, 4'b1001);
    runWalk(v, 16'h0, 2'd3, 1'b0, 1, 2'd0, 0, "R5 code3 read");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule